// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned 32-bit operands and a single carry-in bit, and returns a 32-bit sum together with the carry out of the top bit. The operands are split into four slices of eight bits each. Inside a slice, every carry is formed directly from the per-bit generate (`a AND b`) and propagate (`a OR b`) terms and the slice's carry-in. The recurrence is flattened, so no carry passes bit by bit.

Each slice also exports a group generate and a group propagate. A second-level carry unit combines these four pairs with the adder's carry-in. It produces the carry into slices 1, 2 and 3 and the final carry-out, all in parallel.

A build-time parameter can replace the second level with a chain from slice to slice, where each slice's carry-out feeds the next slice. Both variants give the same results. The sum and carry-out are captured in a register on the rising clock edge, so a result appears one cycle after its operands. A synchronous active-high reset clears that register.

Top module: `cla_adder32`

## Requirements
- R1: While `rst` is high at a rising edge, `sum` and `cout` become 0 after that edge, regardless of the operand inputs.
- R2: When `rst` was low at the previous rising edge, `sum` equals the low 32 bits of `x + y + cin` sampled at that edge.
- R3: `cout` equals bit 32 of the 33-bit value `x + y + cin` sampled at the previous edge, so it is 1 exactly when that value exceeds 2^32 - 1.
- R4: A carry produced in one 8-bit slice reaches the next slice's lowest bit. For example, `x = 0x000000FF` with `y = 0x00000001` gives `0x00000100`, and the same holds at bits 15, 23 and 31.
- R5: When `x XOR y` is all ones and `cin = 1`, the carry crosses all four slices: `sum = 0` and `cout = 1`.
- R6: Alternating operand patterns are summed correctly. `0xAAAAAAAA + 0x55555555` gives `0xFFFFFFFF` with `cout = 0`, or gives 0 with `cout = 1` when `cin = 1`.
- R7: When bit 31 of both operands is 1, `cout` is 1 in the next cycle.
- R8: The slice-chained build (`LOOKAHEAD = 0`) gives the same `sum` and `cout` as the two-level build for every input.
- R9: With both operands zero, `sum` equals `cin` and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the result register |
| x | input | 32 | First unsigned operand |
| y | input | 32 | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Registered sum, one cycle after the operands |
| cout | output | 1 | Registered carry out of bit 31 |

## Verification
Two carry sources can act in the same cycle: the external carry-in, and a generate term inside a lower slice. Both must be resolved through the group propagate terms of every slice above them. This is provoked with an operand pair whose XOR is all ones while `cin` is 1, and with pairs that generate at the top bit of a slice while the slices above all propagate. The result is judged on the full 33-bit value against a behavioural sum. A two-level build and a slice-chained build run side by side, so any disagreement between the second-level carry unit and the chain shows up in the same cycle.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef struct packed {
    logic gen;
    logic prop;
  } grp_t;
endpackage

// File: rtl/cla_block.sv
module cla_block #(
  parameter int W = 8
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  output logic [W-1:0]  s,
  output cla_pkg::grp_t grp
);
  logic [W-1:0] g, p, c;
  logic run, acc;

  always_comb begin
    g = a & b;
    p = a | b;
    c = '0;
    c[0] = cin;
    // each internal carry is a flat sum of products over g, p and cin
    for (int i = 0; i < W - 1; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        run = g[j];
        for (int k = j + 1; k <= i; k++) run = run & p[k];
        acc = acc | run;
      end
      run = cin;
      for (int k = 0; k <= i; k++) run = run & p[k];
      c[i+1] = acc | run;
    end
    // group generate: carry out of the slice assuming zero carry-in
    acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      run = g[j];
      for (int k = j + 1; k < W; k++) run = run & p[k];
      acc = acc | run;
    end
    grp.gen  = acc;
    grp.prop = &p;
    s = a ^ b ^ c;
  end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   c
);
  logic run, acc;

  always_comb begin
    c = '0;
    c[0] = cin;
    for (int i = 0; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        run = gen[j];
        for (int k = j + 1; k <= i; k++) run = run & prop[k];
        acc = acc | run;
      end
      run = cin;
      for (int k = 0; k <= i; k++) run = run & prop[k];
      c[i+1] = acc | run;
    end
  end
endmodule

// File: rtl/cla_adder32.sv
module cla_adder32 #(
  parameter int WIDTH     = 32,
  parameter int BLOCK     = 8,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NBLK = WIDTH / BLOCK;

  logic [NBLK:0]    blk_c;
  logic [NBLK-1:0]  gen, prop;
  logic [WIDTH-1:0] sum_c;

  for (genvar k = 0; k < NBLK; k++) begin : g_slice
    cla_pkg::grp_t grp;
    cla_block #(.W(BLOCK)) u_blk (
      .a   (x[k*BLOCK +: BLOCK]),
      .b   (y[k*BLOCK +: BLOCK]),
      .cin (blk_c[k]),
      .s   (sum_c[k*BLOCK +: BLOCK]),
      .grp (grp)
    );
    assign gen[k]  = grp.gen;
    assign prop[k] = grp.prop;
  end

  if (LOOKAHEAD) begin : g_two_level
    cla_carry_unit #(.N(NBLK)) u_cu (
      .gen  (gen),
      .prop (prop),
      .cin  (cin),
      .c    (blk_c)
    );
  end else begin : g_chain
    assign blk_c[0] = cin;
    for (genvar k = 0; k < NBLK; k++) begin : g_link
      assign blk_c[k+1] = gen[k] | (prop[k] & blk_c[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= blk_c[NBLK];
    end
  end
endmodule

// File: rtl/cla_adder32_chk.sv
module cla_adder32_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  // R1: reset clears the result register on the next edge
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum == '0 && !cout));

  // R2 and R3: registered 33-bit result matches the operands of the prior edge
  p_sum_carry_r2_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout, sum} ==
      ({1'b0, $past(x)} + {1'b0, $past(y)} + {{WIDTH{1'b0}}, $past(cin)})));

  // R5: carry-in crosses every slice when all bits propagate
  p_full_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past((x ^ y) == '1) && $past(cin)) |-> (sum == '0 && cout));

  // R7: top-bit generate forces the carry-out
  p_msb_gen_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(x[WIDTH-1] & y[WIDTH-1])) |-> cout);

  // R9: zero operands pass the carry-in to bit 0 only
  p_zero_ops_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(x == '0 && y == '0)) |->
      (sum == {{(WIDTH-1){1'b0}}, $past(cin)} && !cout));
endmodule

bind cla_adder32 cla_adder32_chk #(.WIDTH(WIDTH)) u_chk (
  .clk (clk), .rst (rst), .x (x), .y (y), .cin (cin), .sum (sum), .cout (cout)
);

// File: tb/cla_adder32_tb.sv
module cla_adder32_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] x = '0, y = '0;
  logic        cin = 1'b0;
  logic [31:0] sum_a, sum_b;
  logic        cout_a, cout_b;
  int          checks = 0;
  int          fails  = 0;
  logic [32:0] expq[$];

  always #2.5 clk = ~clk;

  cla_adder32 #(.LOOKAHEAD(1'b1)) u_dut (
    .clk(clk), .rst(rst), .x(x), .y(y), .cin(cin), .sum(sum_a), .cout(cout_a));
  cla_adder32 #(.LOOKAHEAD(1'b0)) u_dut_rip (
    .clk(clk), .rst(rst), .x(x), .y(y), .cin(cin), .sum(sum_b), .cout(cout_b));

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one vector, then sample at the following falling edge
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c,
                       input string req);
    logic [32:0] e;
    x = a; y = b; cin = c;
    expq.push_back({1'b0, a} + {1'b0, b} + {32'd0, c});
    @(negedge clk);
    e = expq.pop_front();
    check(req, {cout_a, sum_a}, e);
    check({req, " R8"}, {cout_b, sum_b}, {cout_a, sum_a});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    x = 32'hFFFF_FFFF; y = 32'hFFFF_FFFF; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset lookahead", {cout_a, sum_a}, 33'd0);
    check("R1 reset chain", {cout_b, sum_b}, 33'd0);
    rst = 1'b0;

    apply(32'd0, 32'd0, 1'b0, "R9 zero");
    apply(32'd0, 32'd0, 1'b1, "R9 zero cin");
    apply(32'h0000_00FF, 32'd1, 1'b0, "R4 slice0");
    apply(32'h0000_FFFF, 32'd1, 1'b0, "R4 slice1");
    apply(32'h00FF_FFFF, 32'd1, 1'b0, "R4 slice2");
    apply(32'hFFFF_FFFF, 32'd1, 1'b0, "R3 R5 allones plus one");
    apply(32'hFFFF_FFFF, 32'd0, 1'b1, "R5 chain via cin");
    apply(32'h1234_5678, 32'hEDCB_A987, 1'b1, "R5 xor ones cin");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R6 alt");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R6 alt cin");
    apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R6 alt same");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R7 msb gen");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3 max");
    apply(32'h00FF_00FF, 32'h0001_0001, 1'b1, "R4 two slices");

    // reset in mid-run with busy operands
    rst = 1'b1; x = 32'hDEAD_BEEF; y = 32'hCAFE_F00D; cin = 1'b1;
    @(negedge clk);
    check("R1 mid reset", {cout_a, sum_a}, 33'd0);
    check("R1 mid reset chain", {cout_b, sum_b}, 33'd0);
    rst = 1'b0;

    for (int n = 0; n < 3000; n++)
      apply($urandom, $urandom, 1'($urandom), "R2 random");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule